// File: doc/BRIEF.md
# Threshold Binarizer and Bit Packer

This block turns a stream of 8-bit absolute-difference values into a packed binary image. Each accepted beat carries eight difference values, one per lane. Every lane is compared against a threshold, and the eight one-bit results form one packed byte. That byte is written out with an address that counts through the chunk, so a downstream binary image buffer can store it directly. A chunk is 80 by 60 pixels, which is 10 packed bytes per row and 600 packed bytes per chunk.

The threshold for a chunk is fixed when the chunk starts. It comes from one of two sources. It can be a value written into a configuration register. It can also be derived from the chunk's maximum difference value, shifted right by a programmable amount. Configuration writes and changes to the maximum input during a chunk leave that chunk's threshold unchanged. A pulse marks the write of the final packed byte of the chunk. Beats that arrive after that byte are dropped until the next chunk start.

Top module: `thresh_pack`

## Requirements
- R1: After reset, `wr_en`, `chunk_done`, `wr_addr` and `wr_data` are all 0. The manual threshold is 0, the shift is 0 and the manual source is selected. No chunk is open, so beats are ignored until the first `chunk_start`.
- R2: Configuration is written as follows. A cycle with `cfg_thr_we` high stores `cfg_thr` as the manual threshold. A cycle with `cfg_ctrl_we` high stores `cfg_shift` as the shift and `cfg_auto` as the source select (1 = derived from the maximum, 0 = manual). New values apply from the next `chunk_start` that comes in a later cycle.
- R3: On a `chunk_start` cycle the chunk threshold is latched. Its value is `chunk_max >> shift` when the derived source is selected, and the manual threshold otherwise. For the rest of the chunk, changes to `chunk_max` or to the configuration have no effect on the threshold.
- R4: Lane i is `pix_data[8*i+7:8*i]`. Bit i of the packed byte is 1 when lane i is strictly greater than the chunk threshold, and 0 otherwise.
- R5: A beat is accepted when `pix_valid` is high while a chunk is open, or in a `chunk_start` cycle. Its packed byte appears on `wr_data` with `wr_en` high in the cycle after the accepting clock edge. A cycle without an accepted beat gives `wr_en` low in the next cycle.
- R6: The first accepted beat of a chunk is written at address 0, and each further beat at the previous address plus one. A beat given in the same cycle as `chunk_start` is that chunk's address 0 and uses the newly latched threshold. A `chunk_start` with no beat makes the next beat address 0.
- R7: `chunk_done` is high for exactly one cycle: the cycle that carries the write at address 599, the 600th packed byte.
- R8: After the write at address 599, beats are ignored, with no write, until the next `chunk_start`. A `chunk_start` in the middle of a chunk restarts addressing at 0 with a freshly latched threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_thr_we | input | 1 | Write strobe for the manual threshold |
| cfg_thr | input | 8 | Manual threshold value |
| cfg_ctrl_we | input | 1 | Write strobe for shift and source select |
| cfg_shift | input | 3 | Right shift applied to the chunk maximum |
| cfg_auto | input | 1 | 1: threshold derived from maximum, 0: manual |
| chunk_start | input | 1 | Opens a new chunk and latches its threshold |
| chunk_max | input | 8 | Maximum difference value of the starting chunk |
| pix_valid | input | 1 | Beat of eight difference values present |
| pix_data | input | 64 | Eight 8-bit difference values, lane 0 in the low byte |
| wr_en | output | 1 | Packed byte write strobe |
| wr_addr | output | 10 | Byte address within the chunk |
| wr_data | output | 8 | Packed flags, bit i from lane i |
| chunk_done | output | 1 | Pulse with the final byte of the chunk |

## Verification
The bench builds the block with its default parameters: eight lanes of 8 bits, an 80 by 60 chunk and a 3-bit shift. With these values a complete chunk of 600 beats runs in a few hundred cycles. That brings the final address 599, the done pulse and the dropped overrun beat within reach. The shift can reach its extreme settings of 0 and 7. Thresholds at 0 and 0xFF exercise the strict comparison at both ends of the byte range.

// File: rtl/thresh_pack_pkg.sv
package thresh_pack_pkg;

  // Source of the per-chunk threshold.
  typedef enum logic {
    THR_MANUAL   = 1'b0,
    THR_FROM_MAX = 1'b1
  } thr_src_e;

endpackage

// File: rtl/thresh_pack_sel.sv
module thresh_pack_sel
  import thresh_pack_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_thr_we,
  input  logic [PIX_W-1:0]   cfg_thr,
  input  logic               cfg_ctrl_we,
  input  logic [SHIFT_W-1:0] cfg_shift,
  input  logic               cfg_auto,
  input  logic               chunk_start,
  input  logic [PIX_W-1:0]   chunk_max,
  output logic [PIX_W-1:0]   thr_eff
);

  logic [PIX_W-1:0]   man_q, man_d;
  logic [SHIFT_W-1:0] shift_q, shift_d;
  thr_src_e           src_q, src_d;
  logic [PIX_W-1:0]   thr_q, thr_d;
  logic [PIX_W-1:0]   thr_new;

  // Candidate threshold from the configuration in force before this cycle.
  always_comb begin
    if (src_q == THR_FROM_MAX) thr_new = chunk_max >> shift_q;
    else                       thr_new = man_q;
  end

  always_comb begin
    man_d   = man_q;
    shift_d = shift_q;
    src_d   = src_q;
    thr_d   = thr_q;
    if (cfg_thr_we)  man_d = cfg_thr;
    if (cfg_ctrl_we) begin
      shift_d = cfg_shift;
      src_d   = thr_src_e'(cfg_auto);
    end
    if (chunk_start) thr_d = thr_new;
  end

  // A beat in the start cycle already sees the new threshold.
  assign thr_eff = chunk_start ? thr_new : thr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      man_q   <= '0;
      shift_q <= '0;
      src_q   <= THR_MANUAL;
      thr_q   <= '0;
    end else begin
      man_q   <= man_d;
      shift_q <= shift_d;
      src_q   <= src_d;
      thr_q   <= thr_d;
    end
  end

endmodule

// File: rtl/thresh_pack_cmp.sv
module thresh_pack_cmp #(
  parameter int LANES = 8,
  parameter int PIX_W = 8
) (
  input  logic [LANES*PIX_W-1:0] pix_data,
  input  logic [PIX_W-1:0]       thr,
  output logic [LANES-1:0]       flags
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign flags[g] = pix_data[g*PIX_W +: PIX_W] > thr;
  end

endmodule

// File: rtl/thresh_pack_addr.sv
module thresh_pack_addr #(
  parameter int WORDS  = 600,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chunk_start,
  input  logic              pix_valid,
  output logic              accept,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(WORDS - 1);

  logic [ADDR_W-1:0] cnt_q, cnt_d;
  logic              open_q, open_d;

  always_comb begin
    addr   = chunk_start ? '0 : cnt_q;
    accept = pix_valid && (chunk_start || open_q);
    last   = accept && (addr == LAST_ADDR);
  end

  always_comb begin
    cnt_d  = cnt_q;
    open_d = open_q;
    if (chunk_start) begin
      cnt_d  = '0;
      open_d = 1'b1;
    end
    if (accept) begin
      if (last) begin
        cnt_d  = '0;
        open_d = 1'b0;
      end else begin
        cnt_d  = addr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      open_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      open_q <= open_d;
    end
  end

endmodule

// File: rtl/thresh_pack.sv
module thresh_pack #(
  parameter int LANES   = 8,
  parameter int PIX_W   = 8,
  parameter int CHUNK_W = 80,
  parameter int CHUNK_H = 60,
  parameter int SHIFT_W = 3,
  localparam int ROW_WORDS = CHUNK_W / LANES,
  localparam int WORDS     = ROW_WORDS * CHUNK_H,
  localparam int ADDR_W    = $clog2(WORDS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_thr_we,
  input  logic [PIX_W-1:0]       cfg_thr,
  input  logic                   cfg_ctrl_we,
  input  logic [SHIFT_W-1:0]     cfg_shift,
  input  logic                   cfg_auto,
  input  logic                   chunk_start,
  input  logic [PIX_W-1:0]       chunk_max,
  input  logic                   pix_valid,
  input  logic [LANES*PIX_W-1:0] pix_data,
  output logic                   wr_en,
  output logic [ADDR_W-1:0]      wr_addr,
  output logic [LANES-1:0]       wr_data,
  output logic                   chunk_done
);

  logic [PIX_W-1:0]  thr_eff;
  logic [LANES-1:0]  flags;
  logic              accept;
  logic              last;
  logic [ADDR_W-1:0] addr;

  thresh_pack_sel #(.PIX_W(PIX_W), .SHIFT_W(SHIFT_W)) u_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_thr_we  (cfg_thr_we),
    .cfg_thr     (cfg_thr),
    .cfg_ctrl_we (cfg_ctrl_we),
    .cfg_shift   (cfg_shift),
    .cfg_auto    (cfg_auto),
    .chunk_start (chunk_start),
    .chunk_max   (chunk_max),
    .thr_eff     (thr_eff)
  );

  thresh_pack_cmp #(.LANES(LANES), .PIX_W(PIX_W)) u_cmp (
    .pix_data (pix_data),
    .thr      (thr_eff),
    .flags    (flags)
  );

  thresh_pack_addr #(.WORDS(WORDS), .ADDR_W(ADDR_W)) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .chunk_start (chunk_start),
    .pix_valid   (pix_valid),
    .accept      (accept),
    .addr        (addr),
    .last        (last)
  );

  logic              en_q, en_d;
  logic              done_q, done_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LANES-1:0]  data_q, data_d;

  always_comb begin
    en_d   = accept;
    done_d = last;
    addr_d = addr_q;
    data_d = data_q;
    if (accept) begin
      addr_d = addr;
      data_d = flags;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      done_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      en_q   <= en_d;
      done_q <= done_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign wr_en      = en_q;
  assign wr_addr    = addr_q;
  assign wr_data    = data_q;
  assign chunk_done = done_q;

endmodule

// File: rtl/thresh_pack_chk.sv
module thresh_pack_chk #(
  parameter int LANES   = 8,
  parameter int CHUNK_W = 80,
  parameter int CHUNK_H = 60,
  localparam int WORDS  = (CHUNK_W / LANES) * CHUNK_H,
  localparam int ADDR_W = $clog2(WORDS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chunk_start,
  input logic              pix_valid,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              chunk_done
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(WORDS - 1);

  a_r5_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !wr_en);

  a_r6_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_start && pix_valid) |=> (wr_en && wr_addr == '0));

  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !chunk_done && pix_valid && !chunk_start)
      |=> (wr_en && wr_addr == ADDR_W'($past(wr_addr) + 1'b1)));

  a_r6_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr <= LAST_ADDR));

  a_r7_done_last: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_done |-> (wr_en && wr_addr == LAST_ADDR));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_done |=> !chunk_done);

  a_r8_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_done && !chunk_start) |=> !wr_en);

endmodule

bind thresh_pack thresh_pack_chk #(
  .LANES   (LANES),
  .CHUNK_W (CHUNK_W),
  .CHUNK_H (CHUNK_H)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .chunk_start (chunk_start),
  .pix_valid   (pix_valid),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .chunk_done  (chunk_done)
);

// File: tb/thresh_pack_bench.sv
`timescale 1ns/1ps
module thresh_pack_bench;

  localparam int WORDS = 600;
  localparam int WD_NS = 200000 * 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_thr_we = 1'b0;
  logic [7:0]  cfg_thr = '0;
  logic        cfg_ctrl_we = 1'b0;
  logic [2:0]  cfg_shift = '0;
  logic        cfg_auto = 1'b0;
  logic        chunk_start = 1'b0;
  logic [7:0]  chunk_max = '0;
  logic        pix_valid = 1'b0;
  logic [63:0] pix_data = '0;
  logic        wr_en;
  logic [9:0]  wr_addr;
  logic [7:0]  wr_data;
  logic        chunk_done;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  thresh_pack u_thresh_pack (
    .clk(clk), .rst_n(rst_n),
    .cfg_thr_we(cfg_thr_we), .cfg_thr(cfg_thr),
    .cfg_ctrl_we(cfg_ctrl_we), .cfg_shift(cfg_shift), .cfg_auto(cfg_auto),
    .chunk_start(chunk_start), .chunk_max(chunk_max),
    .pix_valid(pix_valid), .pix_data(pix_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .chunk_done(chunk_done)
  );

  // {auto, shift, manual thr, chunk max, pixels (lane 7 high), expected byte}
  localparam logic [91:0] VEC [6] = '{
    {1'b0, 3'd0, 8'h10, 8'hFF, 64'h8010200FFF001110, 8'hAA},
    {1'b1, 3'd1, 8'hAA, 8'h40, 64'h20202100401F2120, 8'h2A},
    {1'b1, 3'd0, 8'h00, 8'hFF, 64'hFFFFFFFFFFFFFFFF, 8'h00},
    {1'b1, 3'd7, 8'h00, 8'hFF, 64'hFF00010301000201, 8'h92},
    {1'b0, 3'd5, 8'h00, 8'h00, 64'h0000000000000100, 8'h02},
    {1'b1, 3'd3, 8'h00, 8'h7F, 64'h1010101010101010, 8'hFF}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic au, input logic [2:0] sh, input logic [7:0] th);
    @(negedge clk);
    cfg_thr_we = 1'b1; cfg_thr = th;
    cfg_ctrl_we = 1'b1; cfg_auto = au; cfg_shift = sh;
    @(negedge clk);
    cfg_thr_we = 1'b0; cfg_ctrl_we = 1'b0;
  endtask

  // Drive one cycle of inputs, then sample just after the following edge.
  task automatic step(input logic st, input logic [7:0] mx, input logic vl, input logic [63:0] px);
    @(negedge clk);
    chunk_start = st; chunk_max = mx; pix_valid = vl; pix_data = px;
    @(posedge clk);
    #1;
    chunk_start = 1'b0; pix_valid = 1'b0;
  endtask

  initial begin
    #(WD_NS);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset wr_en", wr_en, 0);
    chk("R1 reset chunk_done", chunk_done, 0);
    chk("R1 reset wr_addr", wr_addr, 0);
    chk("R1 reset wr_data", wr_data, 0);
    @(negedge clk); rst_n = 1'b1;

    // No chunk open yet: a beat is dropped.
    step(1'b0, 8'h00, 1'b1, 64'hFFFFFFFFFFFFFFFF);
    chk("R1 beat before first start", wr_en, 0);

    // Vector table: R2 config, R3 latch, R4 strict compare and lane order.
    foreach (VEC[i]) begin
      set_cfg(VEC[i][91], VEC[i][90:88], VEC[i][87:80]);
      step(1'b1, VEC[i][79:72], 1'b1, VEC[i][71:8]);
      chk($sformatf("R4 vector %0d wr_data", i), wr_data, VEC[i][7:0]);
      chk($sformatf("R6 vector %0d wr_addr", i), wr_addr, 0);
      chk($sformatf("R5 vector %0d wr_en", i), wr_en, 1);
    end

    // R5: gap cycle gives no write.
    step(1'b0, 8'h00, 1'b0, 64'h0);
    chk("R5 idle cycle wr_en", wr_en, 0);

    // Full chunk: R6 addresses, R7 done pulse.
    set_cfg(1'b0, 3'd0, 8'h7F);
    for (int j = 0; j < WORDS; j++) begin
      step(j == 0, 8'h00, 1'b1, (j % 2 == 0) ? 64'h8080808080808080 : 64'h7F7F7F7F7F7F7F7F);
      chk("R6 full chunk wr_en", wr_en, 1);
      chk("R6 full chunk wr_addr", wr_addr, j);
      chk("R4 full chunk wr_data", wr_data, (j % 2 == 0) ? 8'hFF : 8'h00);
      chk("R7 full chunk chunk_done", chunk_done, j == WORDS - 1);
    end
    // R8: overrun beat dropped, done lasts one cycle.
    step(1'b0, 8'h00, 1'b1, 64'hFFFFFFFFFFFFFFFF);
    chk("R8 overrun wr_en", wr_en, 0);
    chk("R7 done one cycle", chunk_done, 0);

    // R3: threshold held against mid-chunk changes.
    set_cfg(1'b1, 3'd0, 8'h00);
    step(1'b1, 8'h50, 1'b1, 64'h0);
    chk("R3 start beat wr_data", wr_data, 8'h00);
    @(negedge clk);
    cfg_thr_we = 1'b1; cfg_thr = 8'hFF;
    cfg_ctrl_we = 1'b1; cfg_auto = 1'b0; cfg_shift = 3'd0;
    chunk_max = 8'h00; pix_valid = 1'b1; pix_data = 64'h0000000000005051;
    @(posedge clk); #1;
    pix_valid = 1'b0; cfg_thr_we = 1'b0; cfg_ctrl_we = 1'b0;
    chk("R3 mid-chunk cfg write wr_data", wr_data, 8'h01);
    chk("R6 second beat wr_addr", wr_addr, 1);
    step(1'b0, 8'h00, 1'b1, 64'h0000000000005051);
    chk("R3 after cfg write wr_data", wr_data, 8'h01);
    chk("R6 third beat wr_addr", wr_addr, 2);

    // R8/R6: mid-chunk restart without a beat, new threshold 0xFF.
    step(1'b1, 8'h00, 1'b0, 64'h0);
    chk("R6 start without beat wr_en", wr_en, 0);
    step(1'b0, 8'h00, 1'b1, 64'hFFFFFFFFFFFFFFFF);
    chk("R8 restart wr_addr", wr_addr, 0);
    chk("R2 new manual threshold wr_data", wr_data, 8'h00);

    // R1: reset mid-chunk closes it.
    step(1'b0, 8'h00, 1'b1, 64'hFFFFFFFFFFFFFFFF);
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R1 async reset wr_en", wr_en, 0);
    chk("R1 async reset wr_addr", wr_addr, 0);
    @(negedge clk); rst_n = 1'b1;
    step(1'b0, 8'h00, 1'b1, 64'hFFFFFFFFFFFFFFFF);
    chk("R1 beat after reset dropped", wr_en, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule